// File: doc/BRIEF.md
# Dual-Lane Accumulate Shift-Mask Interpolator

This block is an arithmetic helper placed on a simple word-addressed register bus. It holds two accumulators and three base words. Each of its two main lanes works on an accumulator in four steps. It shifts the value right logically. It keeps only a chosen bit window. It can sign-extend that window from the window's top bit. It then adds the lane's base. A third lane adds the third base to the window values of both main lanes.

Software reads a lane result through a look-only port, which changes nothing. It can also read through a consuming port, which returns the same word and, on that clock edge, reloads both accumulators with their lane results. Repeated consuming reads therefore walk a table address or a fixed-point coordinate with no separate write. Separate ports add a short increment to an accumulator, or load both low bases in one write.

A bus read returns data combinationally in the cycle it is presented. Any state change takes effect on the following rising clock edge.

Top module: `interp_top`

## Requirements
- R1: The bus has 16 word addresses: 0 ACC0, 1 ACC1, 2 BASE0, 3 BASE1, 4 BASE2, 5 POP0, 6 POP1, 7 POP2, 8 PEEK0, 9 PEEK1, 10 PEEK2, 11 CTRL0, 12 CTRL1, 13 ADD0, 14 ADD1, 15 BASE01. Reads of ADD0, ADD1 and BASE01 return zero. Synchronous reset clears every register, and an idle bus leaves all state unchanged.
- R2: The window value of lane i is (source >> CTRL[4:0]). Only bits CTRL[9:5] (low bit) through CTRL[14:10] (high bit) are kept, both inclusive, and all other bits become zero. The lane result is BASEi plus this value, modulo 2^32.
- R3: When CTRL bit 15 is set and the window's high bit is 1, every bit above the window's high bit is set to 1 (sign extension).
- R4: When CTRL bit 16 is set, the lane's source is the other lane's accumulator instead of its own.
- R5: When CTRL bit 17 is set, a POP loads this lane's accumulator with the other lane's result instead of its own.
- R6: When CTRL bit 18 is set, the lane result is BASEi plus the unshifted, unmasked source.
- R7: CTRL bits 20:19 are ORed into bits 29:28 of the lane 0 or lane 1 word returned by a PEEK or POP read. They are not ORed into the value written back to the accumulators.
- R8: A CTRL read returns the stored bits 20:0. Bit 23 is set when the shifted lane 0 source has a 1 above lane 0's window high bit, bit 24 is the same test for lane 1, and bit 25 is the OR of bits 23 and 24.
- R9: A PEEK read changes no state. A POP read of any lane returns the same word as the matching PEEK, and on that edge loads both accumulators with their lane results.
- R10: The lane 2 result is BASE2 plus the window values (after R3) of lanes 0 and 1, modulo 2^32.
- R11: A write to ADD0 or ADD1 adds the zero-extended low 24 bits of the write data to that accumulator. The upper data bits are ignored.
- R12: A write to BASE01 loads data bits 15:0 into BASE0 and data bits 31:16 into BASE1, both zero-extended, on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |

## Verification
The bench builds the block with its default widths: 32-bit words, a 24-bit increment and a 16-bit split for the paired base write. With these defaults, every shift amount and window position from 0 to 31 can occur. Random control words therefore reach empty windows (low bit above high bit), full-width windows, sign bits at bit 31, and forced bits landing on shifted data. Each read is compared with a bench model, and each POP's effect is confirmed by reading the accumulators back.

// File: rtl/interp_pkg.sv
package interp_pkg;
    parameter int DW     = 32;
    parameter int AW     = 4;
    parameter int ADD_W  = 24;
    parameter int HALF_W = 16;
    parameter int SH_W   = 5;

    typedef logic [DW-1:0] word_t;

    // Field layout matches control bits 20:0
    typedef struct packed {
        logic [1:0]      force_hi;
        logic            raw;
        logic            xres;
        logic            xin;
        logic            sgn;
        logic [SH_W-1:0] top;
        logic [SH_W-1:0] bot;
        logic [SH_W-1:0] sh;
    } lane_cfg_t;

    localparam int CFG_W = $bits(lane_cfg_t);

    typedef enum logic [AW-1:0] {
        A_ACC0 = 4'd0,  A_ACC1 = 4'd1,  A_BASE0 = 4'd2,  A_BASE1 = 4'd3,
        A_BASE2 = 4'd4, A_POP0 = 4'd5,  A_POP1 = 4'd6,   A_POP2 = 4'd7,
        A_PEEK0 = 4'd8, A_PEEK1 = 4'd9, A_PEEK2 = 4'd10, A_CTRL0 = 4'd11,
        A_CTRL1 = 4'd12, A_ADD0 = 4'd13, A_ADD1 = 4'd14, A_BASE01 = 4'd15
    } reg_addr_e;

    // Ones from bit 0 up to and including bit hi
    function automatic word_t upto_mask(input logic [SH_W-1:0] hi);
        return {DW{1'b1}} >> (SH_W'(DW - 1) - hi);
    endfunction
endpackage

// File: rtl/interp_lane.sv
module interp_lane
    import interp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_cfg_t cfg,
    input  word_t     acc_own,
    input  word_t     acc_other,
    input  word_t     base,
    output word_t     win,
    output word_t     sum,
    output logic      ovf
);
    word_t src, shifted, keep, masked, upper;

    always_comb begin
        src     = cfg.xin ? acc_other : acc_own;
        shifted = src >> cfg.sh;
        upper   = ~upto_mask(cfg.top);
        keep    = ({DW{1'b1}} << cfg.bot) & ~upper;
        masked  = shifted & keep;
        win     = (cfg.sgn && masked[cfg.top]) ? (masked | upper) : masked;
        sum     = base + (cfg.raw ? src : win);
        ovf     = |(shifted & upper);
    end

    // R2: nothing below the window's low bit survives in the window value
    assert_low_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (win & ~({DW{1'b1}} << cfg.bot)) == '0);

    // R3: without sign extension nothing above the window's high bit survives
    assert_no_ext_R3: assert property (@(posedge clk) disable iff (rst)
        !cfg.sgn |-> (win & upper) == '0);
endmodule

// File: rtl/interp_rdmux.sv
module interp_rdmux
    import interp_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  word_t         acc0,
    input  word_t         acc1,
    input  word_t         base0,
    input  word_t         base1,
    input  word_t         base2,
    input  lane_cfg_t     cfg0,
    input  lane_cfg_t     cfg1,
    input  word_t         sum0,
    input  word_t         sum1,
    input  word_t         sum2,
    input  logic          ovf0,
    input  logic          ovf1,
    output word_t         rdata
);
    localparam int PAD_W = DW - CFG_W - 5;
    word_t out0, out1, ctl_hi;

    always_comb begin
        out0   = sum0 | {2'b00, cfg0.force_hi, {(DW-4){1'b0}}};
        out1   = sum1 | {2'b00, cfg1.force_hi, {(DW-4){1'b0}}};
        ctl_hi = {{PAD_W{1'b0}}, ovf0 | ovf1, ovf1, ovf0, 2'b00, {CFG_W{1'b0}}};
        unique case (reg_addr_e'(addr))
            A_ACC0:            rdata = acc0;
            A_ACC1:            rdata = acc1;
            A_BASE0:           rdata = base0;
            A_BASE1:           rdata = base1;
            A_BASE2:           rdata = base2;
            A_POP0,  A_PEEK0:  rdata = out0;
            A_POP1,  A_PEEK1:  rdata = out1;
            A_POP2,  A_PEEK2:  rdata = sum2;
            A_CTRL0:           rdata = ctl_hi | {{(DW-CFG_W){1'b0}}, cfg0};
            A_CTRL1:           rdata = ctl_hi | {{(DW-CFG_W){1'b0}}, cfg1};
            default:           rdata = '0;
        endcase
    end
endmodule

// File: rtl/interp_top.sv
module interp_top
    import interp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata
);
    word_t     acc  [2];
    word_t     base [3];
    lane_cfg_t cfg  [2];
    word_t     win  [2];
    word_t     sum  [2];
    logic      ovf  [2];
    word_t     sum2;
    logic      rd, wr, pop, peek;
    reg_addr_e a;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_lane
            interp_lane u_lane (
                .clk       (clk),
                .rst       (rst),
                .cfg       (cfg[g]),
                .acc_own   (acc[g]),
                .acc_other (acc[1-g]),
                .base      (base[g]),
                .win       (win[g]),
                .sum       (sum[g]),
                .ovf       (ovf[g])
            );
        end
    endgenerate

    always_comb begin
        a    = reg_addr_e'(bus_addr);
        rd   = bus_en && !bus_we;
        wr   = bus_en && bus_we;
        pop  = rd && (a == A_POP0 || a == A_POP1 || a == A_POP2);
        peek = rd && (a == A_PEEK0 || a == A_PEEK1 || a == A_PEEK2);
        sum2 = base[2] + win[0] + win[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '{default: '0};
            base <= '{default: '0};
            cfg  <= '{default: '0};
        end else if (wr) begin
            case (a)
                A_ACC0:   acc[0]  <= bus_wdata;
                A_ACC1:   acc[1]  <= bus_wdata;
                A_BASE0:  base[0] <= bus_wdata;
                A_BASE1:  base[1] <= bus_wdata;
                A_BASE2:  base[2] <= bus_wdata;
                A_CTRL0:  cfg[0]  <= lane_cfg_t'(bus_wdata[CFG_W-1:0]);
                A_CTRL1:  cfg[1]  <= lane_cfg_t'(bus_wdata[CFG_W-1:0]);
                A_ADD0:   acc[0]  <= acc[0] + {{(DW-ADD_W){1'b0}}, bus_wdata[ADD_W-1:0]};
                A_ADD1:   acc[1]  <= acc[1] + {{(DW-ADD_W){1'b0}}, bus_wdata[ADD_W-1:0]};
                A_BASE01: begin
                    base[0] <= {{(DW-HALF_W){1'b0}}, bus_wdata[HALF_W-1:0]};
                    base[1] <= {{HALF_W{1'b0}}, bus_wdata[DW-1:HALF_W]};
                end
                default: ;
            endcase
        end else if (pop) begin
            acc[0] <= cfg[0].xres ? sum[1] : sum[0];
            acc[1] <= cfg[1].xres ? sum[0] : sum[1];
        end
    end

    interp_rdmux u_rdmux (
        .addr  (bus_addr),
        .acc0  (acc[0]),
        .acc1  (acc[1]),
        .base0 (base[0]),
        .base1 (base[1]),
        .base2 (base[2]),
        .cfg0  (cfg[0]),
        .cfg1  (cfg[1]),
        .sum0  (sum[0]),
        .sum1  (sum[1]),
        .sum2  (sum2),
        .ovf0  (ovf[0]),
        .ovf1  (ovf[1]),
        .rdata (bus_rdata)
    );

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !bus_en |=> $stable(acc[0]) && $stable(acc[1]) && $stable(base[2]) && $stable(cfg[0]));

    assert_peek_hold_R9: assert property (@(posedge clk) disable iff (rst)
        peek |=> $stable(acc[0]) && $stable(acc[1]));

    assert_pop_own_R9: assert property (@(posedge clk) disable iff (rst)
        pop && !cfg[0].xres |=> acc[0] == $past(sum[0]));

    assert_pop_cross_R5: assert property (@(posedge clk) disable iff (rst)
        pop && cfg[1].xres |=> acc[1] == $past(sum[0]));

    assert_add_low_R11: assert property (@(posedge clk) disable iff (rst)
        wr && a == A_ADD1 |=> acc[1] == $past(acc[1]) + DW'($past(bus_wdata[ADD_W-1:0])));

    assert_split_R12: assert property (@(posedge clk) disable iff (rst)
        wr && a == A_BASE01 |=> base[0][DW-1:HALF_W] == '0 && base[1][DW-1:HALF_W] == '0);

    assert_force_R7: assert property (@(posedge clk) disable iff (rst)
        rd && a == A_PEEK0 |-> (bus_rdata[29:28] & cfg[0].force_hi) == cfg[0].force_hi);
endmodule

// File: tb/test_interp_top.sv
module test_interp_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_en = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_acc [2];
    logic [31:0] m_base [3];
    logic [31:0] m_cfg [2];

    always #10 clk = ~clk;

    interp_top i_interp_top (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_src(int i);
        return m_cfg[i][16] ? m_acc[1-i] : m_acc[i];
    endfunction

    function automatic logic [31:0] m_shift(int i);
        return m_src(i) >> m_cfg[i][4:0];
    endfunction

    function automatic logic [31:0] m_win(int i);
        logic [31:0] s, w;
        int lo, hi;
        s = m_shift(i); lo = m_cfg[i][9:5]; hi = m_cfg[i][14:10];
        w = 0;
        for (int b = 0; b < 32; b++) if (b >= lo && b <= hi) w[b] = s[b];
        if (m_cfg[i][15] && w[hi])
            for (int b = 0; b < 32; b++) if (b > hi) w[b] = 1'b1;
        return w;
    endfunction

    function automatic logic m_ovf(int i);
        logic [31:0] s;
        int hi;
        logic o;
        s = m_shift(i); hi = m_cfg[i][14:10]; o = 0;
        for (int b = 0; b < 32; b++) if (b > hi && s[b]) o = 1;
        return o;
    endfunction

    function automatic logic [31:0] m_res(int i);
        if (i == 2) return m_base[2] + m_win(0) + m_win(1);
        return m_base[i] + (m_cfg[i][18] ? m_src(i) : m_win(i));
    endfunction

    function automatic logic [31:0] m_read(int i);
        if (i == 2) return m_res(2);
        return m_res(i) | {2'b00, m_cfg[i][20:19], 28'h0};
    endfunction

    function automatic logic [31:0] m_ctrl(int i);
        logic o0, o1;
        o0 = m_ovf(0); o1 = m_ovf(1);
        return {6'h0, o0 | o1, o1, o0, 2'b00, m_cfg[i][20:0]};
    endfunction

    task automatic wr(input logic [3:0] ad, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = ad; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        case (ad)
            0, 1:   m_acc[ad] = d;
            2, 3, 4: m_base[ad-2] = d;
            11, 12: m_cfg[ad-11] = d & 32'h001F_FFFF;
            13, 14: m_acc[ad-13] = m_acc[ad-13] + {8'h0, d[23:0]};
            15: begin m_base[0] = {16'h0, d[15:0]}; m_base[1] = {16'h0, d[31:16]}; end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] ad, output logic [31:0] q);
        logic [31:0] n0, n1;
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = ad;
        #3 q = bus_rdata;
        @(negedge clk);
        bus_en = 0;
        if (ad >= 5 && ad <= 7) begin
            n0 = m_cfg[0][17] ? m_res(1) : m_res(0);
            n1 = m_cfg[1][17] ? m_res(0) : m_res(1);
            m_acc[0] = n0; m_acc[1] = n1;
        end
    endtask

    task automatic expect_rd(input logic [3:0] ad, input logic [31:0] e, input string req);
        logic [31:0] q;
        rd(ad, q);
        check(q === e, req, q, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] q, e, pk;
        void'($urandom(32'd1234));
        m_acc = '{default: 0}; m_base = '{default: 0}; m_cfg = '{default: 0};
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state and map
        for (int ad = 0; ad < 16; ad++) expect_rd(4'(ad), 32'h0, "R1 reset");
        wr(15, 32'hFFFF_FFFF); expect_rd(15, 32'h0, "R1 base01 reads zero");
        expect_rd(13, 32'h0, "R1 add reads zero");

        // R2 directed shift and window
        wr(0, 32'h0000_1234); wr(11, 32'h0000_1C04); wr(2, 32'h100);
        expect_rd(8, 32'h0000_0123, "R2 window");
        // R3 sign extension
        wr(0, 32'h80); wr(11, 32'h0000_9C00);
        expect_rd(8, 32'h0000_0100 + 32'hFFFF_FF80, "R3 sign extend");
        // R8 overflow flags
        wr(0, 32'hF0); wr(11, 32'h0000_0C00);
        expect_rd(11, 32'h0280_0C00, "R8 overflow lane0");
        expect_rd(12, 32'h0280_0000, "R8 ctrl1 flags");
        // R11 add ignores upper bits
        wr(0, 32'h10); wr(13, 32'hAB00_0005);
        expect_rd(0, 32'h15, "R11 add");
        wr(14, 32'hFFFF_FFFF); expect_rd(1, 32'h00FF_FFFF, "R11 add max");
        // R12 paired base
        wr(15, 32'hBEEF_1234);
        expect_rd(2, 32'h1234, "R12 base0"); expect_rd(3, 32'hBEEF, "R12 base1");
        // R4 cross input
        wr(0, 5); wr(1, 32'h70); wr(11, 32'h0001_7C00); wr(2, 32'h1000);
        expect_rd(8, 32'h1070, "R4 cross input");
        // R6 raw add
        wr(0, 32'h1234); wr(11, 32'h0004_0C04); wr(2, 1);
        expect_rd(8, 32'h1235, "R6 raw");
        // R10 lane2
        wr(11, 32'h0000_1C00); wr(12, 32'h0000_0C00); wr(0, 32'h1FF); wr(1, 32'h3F); wr(4, 32'h1000);
        expect_rd(10, 32'h1000 + 32'hFF + 32'hF, "R10 lane2");
        // R9 peek leaves state, pop returns same value and reloads
        wr(11, 32'h0000_7C00); wr(12, 32'h0000_7C00); wr(0, 10); wr(1, 20); wr(2, 1); wr(3, 2);
        rd(8, pk); check(pk === 32'd11, "R9 peek", pk, 32'd11);
        expect_rd(0, 32'd10, "R9 peek no change");
        rd(5, q); check(q === pk, "R9 pop value", q, pk);
        expect_rd(0, 32'd11, "R9 pop acc0"); expect_rd(1, 32'd22, "R9 pop acc1");
        // R5 cross result
        wr(11, 32'h0002_7C00); wr(0, 10); wr(1, 20);
        rd(6, q);
        expect_rd(0, 32'd22, "R5 cross result acc0"); expect_rd(1, 32'd22, "R5 acc1");
        // R7 forced bits in read only
        wr(11, 32'h0018_7C00); wr(0, 32'h5); wr(2, 0);
        expect_rd(8, 32'h3000_0005, "R7 force peek");
        rd(5, q); check(q === 32'h3000_0005, "R7 force pop", q, 32'h3000_0005);
        expect_rd(0, 32'h5, "R7 not written back");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: wr(4'($urandom_range(0, 1)), $urandom());
                1: wr(4'($urandom_range(2, 4)), $urandom());
                2, 3: wr(4'($urandom_range(11, 12)), $urandom());
                4: wr(4'($urandom_range(13, 14)), $urandom());
                5: wr(15, $urandom());
                default: ;
            endcase
            for (int l = 0; l < 3; l++) expect_rd(4'(8 + l), m_read(l), "R2 random peek");
            expect_rd(11, m_ctrl(0), "R8 random ctrl0");
            expect_rd(12, m_ctrl(1), "R8 random ctrl1");
            if (op >= 7) begin
                int l;
                l = $urandom_range(0, 2);
                e = m_read(l);
                rd(4'(5 + l), q);
                check(q === e, "R9 random pop", q, e);
                expect_rd(0, m_acc[0], "R9 random acc0");
                expect_rd(1, m_acc[1], "R9 random acc1");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule